// File: doc/BRIEF.md
# Serial Register Access Port

This block is a slave serial port that gives a host access to a small 8-bit register space with 6-bit addresses. The host pulls an active-low select low and then clocks one sixteen-clock frame. The frame carries, in order, a direction bit, six address bits, one unused slot and eight data bits. Writes commit into on-chip registers. Read data comes back on a separate serial output. After every single access the host must return the select high.

The block runs entirely in the on-chip clock domain. The three host pins are resynchronised, and edges of the host serial clock are found by oversampling. The register space holds a control register that drives a configuration output, an interrupt mask, a latched alarm status register and a read-only view of the live alarm levels. Every change of an alarm input latches its status bit. The active-low interrupt output is asserted while any unmasked latched bit is set. Reading the status register clears it.

Top module: `serial_cfg_port`

## Requirements
- R1: After a synchronous active-low reset, the serial output is 0, the interrupt output is high (inactive), the control register (and so `cfg_out`) is 0x00, the mask register is 0x00 and all latched status bits are 0.
- R2: The frame layout is fixed. Rising edge 1 carries the direction bit (1 = read, 0 = write). Rising edges 2 to 7 carry address bits A0 to A5, least significant first. Rising edge 8 is an unused slot. Rising edges 9 to 16 carry data bits D0 to D7, least significant first.
- R3: A write frame commits its data to the addressed register on its 16th rising serial-clock edge. Address 0x00 is the control register, whose value appears on `cfg_out`. Address 0x01 is the interrupt mask.
- R4: If the select returns high before the 16th rising edge, the frame has no effect on any register.
- R5: In a read frame, the serial output presents D0 after falling edge 8 and D(i) after falling edge 8+i, up to D7 after falling edge 15. At every other time it is 0: before falling edge 8, after falling edge 16, during write frames and while the select is high.
- R6: There is no burst access. Serial clocks beyond the 16th within one select-low period write nothing and leave the serial output at 0.
- R7: Any change of an alarm input bit, in either direction, sets that bit in the latched status register at address 0x02.
- R8: Reading address 0x02 returns the latched bits and clears them. The interrupt output is low exactly while some latched bit is set whose mask bit is 0.
- R9: A mask bit of 1 keeps its alarm from asserting the interrupt, but the bit is still latched and still readable.
- R10: If an alarm change falls in the same clock cycle as the read of address 0x02, the read returns the earlier latched value and the new bit stays latched.
- R11: Address 0x03 reads the live alarm levels and ignores writes. All other addresses above 0x03 read 0x00 and ignore writes.
- R12: The host pins pass through a two-stage synchroniser. A rising serial-clock edge on the pin therefore acts on the third system clock edge after the pin changes. For the 16th edge of a write, `cfg_out` is unchanged two clocks after the pin change and updated after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Active-low select from the host |
| spi_sclk | input | 1 | Host serial clock |
| spi_sdi | input | 1 | Serial data from the host |
| spi_sdo | output | 1 | Serial read data to the host |
| alarm_in | input | ALARM_W | Alarm levels, synchronous to clk |
| cfg_out | output | 8 | Control register contents |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The status read, which both captures and clears the latched bits on the 7th rising serial edge, can land in the same system clock cycle as a new alarm change that sets a bit. The bench uses the fixed synchroniser latency to place the alarm change exactly two clocks after it raises the 7th serial clock edge. It then judges the outcome at the ports. The read must return only the earlier bit, the interrupt must stay asserted afterwards, and a second read must return the new bit alone.

// File: rtl/scp_pkg.sv
// Shared constants for the serial register access port.
// Assumes a fixed 16-slot frame: direction, six address bits, unused slot, eight data bits.
package scp_pkg;
    localparam int ADDR_W     = 6;
    localparam int DATA_W     = 8;
    localparam int FRAME_LEN  = 1 + ADDR_W + 1 + DATA_W;
    localparam int CNT_W      = $clog2(FRAME_LEN + 1);
    // slot index = number of rising edges already seen when the bit arrives
    localparam int SLOT_DIR   = 0;
    localparam int SLOT_A0    = 1;
    localparam int SLOT_D0    = SLOT_A0 + ADDR_W + 1;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    localparam addr_t ADR_CTRL = 6'h00;
    localparam addr_t ADR_MASK = 6'h01;
    localparam addr_t ADR_STS  = 6'h02;
    localparam addr_t ADR_LVL  = 6'h03;
endpackage

// File: rtl/scp_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous single-bit inputs.
// Assumes each bit is independent; the reset value is chosen per bit.
module scp_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // first capture stage from the pins
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= RST_VAL;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                // further stages to settle metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[s] <= RST_VAL;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/scp_frame.sv
// Frame engine: finds serial clock edges, collects direction, address and data,
// issues one-cycle read and write strobes, and shifts read data out LSB first.
// Assumes synchronised inputs and serial half periods of several system clocks.
module scp_frame
    import scp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cs_act,
    input  logic  sclk_s,
    input  logic  sdi_s,
    output logic  wr_en,
    output logic  rd_en,
    output addr_t acc_addr,
    output data_t wr_data,
    input  data_t rd_data,
    output logic  sdo
);
    logic             sclk_d;
    logic             rise, fall;
    logic [CNT_W-1:0] cnt_q;
    logic             dir_q;
    addr_t            ash_q;
    logic [DATA_W-2:0] dsh_q;
    data_t            rbuf_q;
    logic             sdo_q;

    assign rise = sclk_s & ~sclk_d;
    assign fall = ~sclk_s & sclk_d;

    // previous serial clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    // strobes: read fetch on the last address edge, write on the final edge
    assign rd_en    = cs_act & rise & dir_q & (cnt_q == CNT_W'(SLOT_A0 + ADDR_W - 1));
    assign wr_en    = cs_act & rise & ~dir_q & (cnt_q == CNT_W'(FRAME_LEN - 1));
    assign acc_addr = dir_q ? {sdi_s, ash_q[ADDR_W-2:0]} : ash_q;
    assign wr_data  = {sdi_s, dsh_q};

    // slot counter and input shift registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dir_q <= 1'b0;
            ash_q <= '0;
            dsh_q <= '0;
        end else if (!cs_act) begin
            cnt_q <= '0;
            dir_q <= 1'b0;
        end else if (rise && cnt_q < CNT_W'(FRAME_LEN)) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(SLOT_DIR)) dir_q <= sdi_s;
            for (int i = 0; i < ADDR_W; i++)
                if (cnt_q == CNT_W'(SLOT_A0 + i)) ash_q[i] <= sdi_s;
            for (int i = 0; i < DATA_W - 1; i++)
                if (cnt_q == CNT_W'(SLOT_D0 + i)) dsh_q[i] <= sdi_s;
        end
    end

    // read buffer captured on the fetch strobe
    always_ff @(posedge clk) begin
        if (!rst_n)     rbuf_q <= '0;
        else if (rd_en) rbuf_q <= rd_data;
    end

    // serial output updated on falling edges inside the read data window
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            sdo_q <= 1'b0;
        end else if (fall) begin
            sdo_q <= 1'b0;
            for (int i = 0; i < DATA_W; i++)
                if (dir_q && cnt_q == CNT_W'(SLOT_D0 + i)) sdo_q <= rbuf_q[i];
        end
    end

    assign sdo = sdo_q;
endmodule

// File: rtl/scp_regs.sv
// Register space: control, interrupt mask, latched alarm status (clear on read)
// and live alarm view. Assumes alarm_in is synchronous to clk and ALARM_W <= 8.
module scp_regs
    import scp_pkg::*;
#(
    parameter int ALARM_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  addr_t              acc_addr,
    input  data_t              wr_data,
    output data_t              rd_data,
    input  logic [ALARM_W-1:0] alarm_in,
    output data_t              cfg,
    output logic               irq_n
);
    data_t              ctrl_q, mask_q;
    logic [ALARM_W-1:0] sts_q, prev_q, evt;
    logic               clr;

    assign evt = alarm_in ^ prev_q;
    assign clr = rd_en && (acc_addr == ADR_STS);

    // writable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            if (acc_addr == ADR_CTRL) ctrl_q <= wr_data;
            if (acc_addr == ADR_MASK) mask_q <= wr_data;
        end
    end

    // alarm history and latched status; a new event outranks the clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            sts_q  <= '0;
        end else begin
            prev_q <= alarm_in;
            sts_q  <= (clr ? '0 : sts_q) | evt;
        end
    end

    // read multiplexer
    always_comb begin
        unique case (acc_addr)
            ADR_CTRL: rd_data = ctrl_q;
            ADR_MASK: rd_data = mask_q;
            ADR_STS:  rd_data = DATA_W'(sts_q);
            ADR_LVL:  rd_data = DATA_W'(alarm_in);
            default:  rd_data = '0;
        endcase
    end

    assign cfg   = ctrl_q;
    assign irq_n = ~|(sts_q & ~mask_q[ALARM_W-1:0]);
endmodule

// File: rtl/serial_cfg_port.sv
// Top of the serial register access port: synchronises the host pins,
// runs the frame engine and holds the register space.
// Assumes one access per select-low period.
module serial_cfg_port
    import scp_pkg::*;
#(
    parameter int ALARM_W     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spi_cs_n,
    input  logic               spi_sclk,
    input  logic               spi_sdi,
    output logic               spi_sdo,
    input  logic [ALARM_W-1:0] alarm_in,
    output logic [DATA_W-1:0]  cfg_out,
    output logic               irq_n
);
    logic [2:0] pin_s;
    logic       wr_en, rd_en;
    addr_t      acc_addr;
    data_t      wr_data, rd_data;

    scp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({spi_cs_n, spi_sclk, spi_sdi}),
        .q    (pin_s)
    );

    scp_frame u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_act  (~pin_s[2]),
        .sclk_s  (pin_s[1]),
        .sdi_s   (pin_s[0]),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .acc_addr(acc_addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .sdo     (spi_sdo)
    );

    scp_regs #(.ALARM_W(ALARM_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .acc_addr(acc_addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .alarm_in(alarm_in),
        .cfg     (cfg_out),
        .irq_n   (irq_n)
    );
endmodule

// File: rtl/scp_checker.sv
// Port-level properties of the serial register access port, bound to the top.
module scp_checker #(
    parameter int ALARM_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               spi_cs_n,
    input logic               spi_sdo,
    input logic [ALARM_W-1:0] alarm_in,
    input logic [7:0]         cfg_out,
    input logic               irq_n
);
    logic [2:0] since_rst;

    // cycles elapsed since reset, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)                since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 1'b1;
    end

    // R5
    sdo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd3 && spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2)) |=> !spi_sdo);

    // R4
    cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd3 && spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2)) |=> $stable(cfg_out));

    // R3
    cfg_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd2 && !$stable(cfg_out)) |-> !$past(spi_cs_n));

    // R8
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd2 && $rose(irq_n)) |-> !$past(spi_cs_n));

    // R7
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd3 && $fell(irq_n)) |->
            ($past(alarm_in) != $past(alarm_in, 2)) || !$past(spi_cs_n));
endmodule

bind serial_cfg_port scp_checker #(.ALARM_W(ALARM_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .spi_cs_n(spi_cs_n),
    .spi_sdo (spi_sdo),
    .alarm_in(alarm_in),
    .cfg_out (cfg_out),
    .irq_n   (irq_n)
);

// File: tb/serial_cfg_port_test.sv
// Directed bench: one task per scenario, each checking its own results.
module serial_cfg_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int AW         = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic          sdo;
    logic [AW-1:0] alarm = '0;
    logic [7:0]    cfg;
    logic          irq_n;
    logic [7:0]    lat_pre, lat_post;
    int            total = 0, bad = 0;
    bit            done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_cfg_port #(.ALARM_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_sdi(sdi),
        .spi_sdo(sdo), .alarm_in(alarm), .cfg_out(cfg), .irq_n(irq_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // one select-low period with nclk serial clocks; optional alarm change
    // two system clocks after raising the serial clock of slot hook_k
    task automatic xfer(input logic dir, input logic [5:0] a, input logic [7:0] wd,
                        input int nclk, input int hook_k, input logic [AW-1:0] hook_v,
                        output logic [7:0] rd, output logic stray);
        logic [15:0] bits;
        bits = {wd, 1'b0, a, dir};
        rd = '0; stray = 1'b0;
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int k = 0; k < nclk; k++) begin
            sdi = (k < 16) ? bits[k] : k[0];
            repeat (HALF) @(negedge clk);
            if (dir && k >= 8 && k < 16) rd[k-8] = sdo;
            else if (sdo !== 1'b0) stray = 1'b1;
            sclk = 1'b1;
            for (int j = 1; j <= HALF; j++) begin
                @(negedge clk);
                if (k == hook_k && j == 2) alarm = hook_v;
                if (k == 15 && j == 2) lat_pre = cfg;
                if (k == 15 && j == 3) lat_post = cfg;
            end
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        if (sdo !== 1'b0) stray = 1'b1;
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
        if (sdo !== 1'b0) stray = 1'b1;
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d, input string req);
        logic [7:0] r; logic st;
        xfer(1'b0, a, d, 16, -1, '0, r, st);
        chk({req, " sdo quiet in write"}, st, 0);
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d, input string req);
        logic st;
        xfer(1'b1, a, 8'h00, 16, -1, '0, d, st);
        chk({req, " sdo outside window"}, st, 0);
    endtask

    task automatic t_reset;
        chk("R1 sdo", sdo, 0);
        chk("R1 irq_n", irq_n, 1);
        chk("R1 cfg", cfg, 8'h00);
    endtask

    task automatic t_write_read;
        logic [7:0] r;
        wr(6'h00, 8'hA5, "R2");
        chk("R3 cfg after write", cfg, 8'hA5);
        chk("R12 cfg two clocks after edge 16", lat_pre, 8'h00);
        chk("R12 cfg three clocks after edge 16", lat_post, 8'hA5);
        rd(6'h00, r, "R5");
        chk("R5 read ctrl LSB first", r, 8'hA5);
        rd(6'h01, r, "R1");
        chk("R1 mask reset", r, 8'h00);
        wr(6'h01, 8'h3C, "R3");
        rd(6'h01, r, "R2");
        chk("R2 mask readback", r, 8'h3C);
        wr(6'h01, 8'h00, "R3");
    endtask

    task automatic t_abort;
        logic [7:0] r; logic st;
        xfer(1'b0, 6'h00, 8'h11, 15, -1, '0, r, st);
        chk("R4 aborted write", cfg, 8'hA5);
        rd(6'h00, r, "R4");
        chk("R4 ctrl after abort", r, 8'hA5);
    endtask

    task automatic t_burst;
        logic [7:0] r; logic st;
        xfer(1'b0, 6'h00, 8'h5A, 24, -1, '0, r, st);
        chk("R6 extra clocks after write", cfg, 8'h5A);
        chk("R6 sdo in write burst", st, 0);
        xfer(1'b1, 6'h00, 8'h00, 24, -1, '0, r, st);
        chk("R6 read data with extra clocks", r, 8'h5A);
        chk("R6 sdo low on extra clocks", st, 0);
    endtask

    task automatic t_alarm;
        logic [7:0] r;
        alarm = 8'h05;
        repeat (3) @(negedge clk);
        chk("R7 irq on rise", irq_n, 0);
        rd(6'h02, r, "R8");
        chk("R8 status read", r, 8'h05);
        chk("R8 irq released", irq_n, 1);
        alarm = 8'h00;
        repeat (3) @(negedge clk);
        chk("R7 irq on fall", irq_n, 0);
        rd(6'h02, r, "R7");
        chk("R7 falling change latched", r, 8'h05);
        rd(6'h02, r, "R8");
        chk("R8 cleared", r, 8'h00);
    endtask

    task automatic t_mask;
        logic [7:0] r;
        wr(6'h01, 8'h01, "R9");
        alarm = 8'h01;
        repeat (3) @(negedge clk);
        chk("R9 masked bit keeps irq high", irq_n, 1);
        rd(6'h02, r, "R9");
        chk("R9 masked bit latched", r, 8'h01);
        wr(6'h01, 8'h00, "R9");
        alarm = 8'h00;
        repeat (3) @(negedge clk);
        rd(6'h02, r, "R9");
        chk("R9 irq after clear", irq_n, 1);
    endtask

    task automatic t_space;
        logic [7:0] r;
        alarm = 8'h96;
        repeat (2) @(negedge clk);
        rd(6'h03, r, "R11");
        chk("R11 live levels", r, 8'h96);
        wr(6'h03, 8'hFF, "R11");
        rd(6'h03, r, "R11");
        chk("R11 live ignores write", r, 8'h96);
        wr(6'h2A, 8'hC3, "R11");
        rd(6'h2A, r, "R11");
        chk("R11 unmapped reads zero", r, 8'h00);
        chk("R11 unmapped write leaves cfg", cfg, 8'h5A);
        alarm = 8'h00;
        repeat (2) @(negedge clk);
        rd(6'h02, r, "R11");
        rd(6'h02, r, "R11");
        chk("R11 status clean", r, 8'h00);
    endtask

    task automatic t_collide;
        logic [7:0] r; logic st;
        alarm = 8'h04;
        repeat (3) @(negedge clk);
        xfer(1'b1, 6'h02, 8'h00, 16, 6, 8'h06, r, st);
        chk("R10 read returns earlier value", r, 8'h04);
        chk("R10 new event keeps irq", irq_n, 0);
        rd(6'h02, r, "R10");
        chk("R10 new bit survives clear", r, 8'h02);
        chk("R8 irq high after second read", irq_n, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset;
        t_write_read;
        t_abort;
        t_burst;
        t_alarm;
        t_mask;
        t_space;
        t_collide;
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule